// File: doc/BRIEF.md
# Key-protected windowed watchdog timer

This block is a down-counting watchdog on a small 32-bit register bus. Software controls it only through a write-only command register that takes 16-bit key codes. One code starts the watchdog, one reloads its down-counter, and one opens the three timing registers (prescaler, reload value and window) for writing. Any other key write closes them again. Once started, the watchdog cannot be stopped. It asks for a reset if software fails to reload it in time. It also asks for a reset if software reloads it too early, that is, while the count is still above the window value.

The bus has a word index, a write strobe, a read strobe and two half-word enables. Only the low half-word of each register holds data, so the block accepts both 16-bit and 32-bit writes. A status register shows busy flags that model the delay of an update to a timing register. A debug-halt input freezes the count when a control bit allows it. The reset request comes out as a registered pulse that lasts one clock.

Top module: `keyed_window_wdt`

## Requirements
- R1: After reset the timing registers are locked. A write of 0x5555 to bits 15:0 of the key register (word index 0) unlocks them, and writes then take effect: prescaler at index 1 (bits 2:0), reload at index 2 (bits 11:0), window at index 4 (bits 11:0).
- R2: Any key write other than 0x5555 locks the timing registers again, including 0xAAAA and 0xCCCC. A write to a timing register while it is locked leaves that register unchanged.
- R3: The down-counter decrements by one on each prescaled tick. Ticks come every 4 × 2^min(PR,6) clocks, so a prescaler value of 7 acts as 6 (divide by 256).
- R4: Key 0xCCCC starts the watchdog and loads the counter from the reload register. No later key or register write stops it.
- R5: Key 0xAAAA loads the counter from the reload register and restarts the prescaler phase. Regular reloads prevent any reset request while the window value is 0xFFF.
- R6: When a tick arrives while the counter is zero, rst_req is high for exactly one clock and the counter reloads from the reload register. rst_req never rises before the watchdog has been started.
- R7: A reload key received while the watchdog runs and the counter is above the window value raises rst_req for one clock. This happens only if the window is not 0xFFF. A reload received with the counter at or below the window raises no request.
- R8: The key register reads as 0. After reset, reads return prescaler 0, reload 0xFFF, window 0xFFF, status 0 and control 0. Read data appears on bus_rdata in the clock after the read strobe, and it holds until the next read.
- R9: The status register (index 3) shows a busy flag for each timing register: bit 0 prescaler, bit 1 reload, bit 2 window. A flag is set for BUSY_CYCLES clocks after an accepted write to its register, then clears.
- R10: When dbg_halt is high and control bit 0 (index 5, writable at any time) is set, the counter and the prescaler hold their values. When either is low, counting continues.
- R11: Only bits 15:0 carry data, and they are written when bus_hw_en[0] is set. A write with only bus_hw_en[1] set changes no register. It is also not a key write, so it neither unlocks nor locks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_widx | input | 3 | Register word index |
| bus_hw_en | input | 2 | Half-word enables: bit 0 for bits 15:0, bit 1 for bits 31:16 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dbg_halt | input | 1 | Debug-halt indication |
| rst_req | output | 1 | One-clock reset request pulse |

## Verification
The assertions assume a bus that never raises write and read in the same clock. They also assume inputs that change only between clock edges. The bench drives every access from tasks on the falling edge and performs one access at a time, so both assumptions hold. The freeze property assumes dbg_halt is stable across the edge it is sampled on. The bench changes dbg_halt only between accesses, at a falling edge.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_RELOAD = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;

  typedef enum logic [2:0] {
    IDX_KEY  = 3'd0,
    IDX_PRE  = 3'd1,
    IDX_RLD  = 3'd2,
    IDX_STAT = 3'd3,
    IDX_WIN  = 3'd4,
    IDX_CTL  = 3'd5
  } reg_idx_e;

  typedef struct packed {
    logic start;
    logic reload;
  } key_cmd_t;
endpackage

// File: rtl/wdg_bus_regs.sv
module wdg_bus_regs
  import wdg_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int PR_W        = 3,
  parameter int BUSY_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [2:0]       widx,
  input  logic [1:0]       hw_en,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output key_cmd_t         cmd,
  output logic [PR_W-1:0]  pr_o,
  output logic [CNT_W-1:0] rl_o,
  output logic [CNT_W-1:0] win_o,
  output logic             dbg_stop_o
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam int NFIELD = 3;

  logic             locked_q;
  logic [PR_W-1:0]  pr_q;
  logic [CNT_W-1:0] rl_q, win_q;
  logic             dbg_q;
  logic [31:0]      rdata_q;
  logic             lo_wr, key_wr;
  logic [KEY_W-1:0] key_val;
  logic [NFIELD-1:0] cfg_wr, busy;
  logic             unused_hi;

  assign unused_hi = ^{wdata[31:16], hw_en[1]};
  assign lo_wr   = wr & hw_en[0];
  assign key_val = wdata[KEY_W-1:0];
  assign key_wr  = lo_wr && (widx == IDX_KEY);
  assign cfg_wr[0] = lo_wr && !locked_q && (widx == IDX_PRE);
  assign cfg_wr[1] = lo_wr && !locked_q && (widx == IDX_RLD);
  assign cfg_wr[2] = lo_wr && !locked_q && (widx == IDX_WIN);
  assign cmd.start  = key_wr && (key_val == KEY_START);
  assign cmd.reload = key_wr && (key_val == KEY_RELOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b1;
      pr_q     <= '0;
      rl_q     <= '1;
      win_q    <= '1;
      dbg_q    <= 1'b0;
    end else begin
      if (key_wr) locked_q <= (key_val != KEY_UNLOCK);
      if (cfg_wr[0]) pr_q  <= wdata[PR_W-1:0];
      if (cfg_wr[1]) rl_q  <= wdata[CNT_W-1:0];
      if (cfg_wr[2]) win_q <= wdata[CNT_W-1:0];
      if (lo_wr && widx == IDX_CTL) dbg_q <= wdata[0];
    end
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_busy
    logic [BUSY_W-1:0] left_q;
    always_ff @(posedge clk) begin
      if (rst)                left_q <= '0;
      else if (cfg_wr[g])     left_q <= BUSY_W'(BUSY_CYCLES);
      else if (left_q != '0)  left_q <= left_q - 1'b1;
    end
    assign busy[g] = (left_q != '0);

    assert_busy_set_R9: assert property (@(posedge clk) disable iff (rst)
      cfg_wr[g] |=> busy[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd) begin
      case (widx)
        IDX_PRE:  rdata_q <= 32'(pr_q);
        IDX_RLD:  rdata_q <= 32'(rl_q);
        IDX_STAT: rdata_q <= 32'(busy);
        IDX_WIN:  rdata_q <= 32'(win_q);
        IDX_CTL:  rdata_q <= 32'(dbg_q);
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata      = rdata_q;
  assign pr_o       = pr_q;
  assign rl_o       = rl_q;
  assign win_o      = win_q;
  assign dbg_stop_o = dbg_q;

  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (lo_wr && locked_q && widx == IDX_RLD) |=> $stable(rl_q));
  assert_relock_R2: assert property (@(posedge clk) disable iff (rst)
    (key_wr && key_val != KEY_UNLOCK) |=> locked_q);
  assert_upper_only_R11: assert property (@(posedge clk) disable iff (rst)
    (wr && !hw_en[0]) |=> ($stable(locked_q) && $stable(win_q)));
endmodule

// File: rtl/wdg_tick.sv
module wdg_tick #(
  parameter int PR_W      = 3,
  parameter int MAX_SHIFT = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            freeze,
  input  logic            clear,
  input  logic [PR_W-1:0] pr,
  output logic            tick
);
  localparam int PRE_W = MAX_SHIFT + 3;

  logic [PRE_W-1:0] pre_q, ratio_m1;
  logic [PR_W-1:0]  shift;

  assign shift    = (pr > PR_W'(MAX_SHIFT)) ? PR_W'(MAX_SHIFT) : pr;
  assign ratio_m1 = (PRE_W'(4) << shift) - PRE_W'(1);
  assign tick     = run && !freeze && !clear && (pre_q >= ratio_m1);

  always_ff @(posedge clk) begin
    if (rst || clear)        pre_q <= '0;
    else if (run && !freeze) pre_q <= tick ? '0 : pre_q + 1'b1;
  end

  assert_prescaler_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (run && freeze && !clear) |=> $stable(pre_q));
endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter
  import wdg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  key_cmd_t         cmd,
  input  logic             tick,
  input  logic             freeze,
  input  logic [CNT_W-1:0] rl,
  input  logic [CNT_W-1:0] win,
  output logic             started,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q;
  logic             started_q, req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      cnt_q     <= '1;
      req_q     <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (cmd.start) begin
        started_q <= 1'b1;
        cnt_q     <= rl;
      end else if (cmd.reload) begin
        cnt_q <= rl;
        if (started_q && (win != '1) && (cnt_q > win)) req_q <= 1'b1;
      end else if (tick) begin
        if (cnt_q == '0) begin
          req_q <= 1'b1;
          cnt_q <= rl;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign started = started_q;
  assign rst_req = req_q;

  assert_decrement_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !cmd.start && !cmd.reload && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_no_stop_R4: assert property (@(posedge clk) disable iff (rst)
    started_q |=> started_q);
  assert_quiet_before_start_R6: assert property (@(posedge clk) disable iff (rst)
    (!started_q && !cmd.start) |=> !req_q);
  assert_count_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (started_q && freeze && !cmd.start && !cmd.reload) |=> $stable(cnt_q));
endmodule

// File: rtl/keyed_window_wdt.sv
module keyed_window_wdt
  import wdg_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int PR_W        = 3,
  parameter int MAX_SHIFT   = 6,
  parameter int BUSY_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_widx,
  input  logic [1:0]  bus_hw_en,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        dbg_halt,
  output logic        rst_req
);
  key_cmd_t         cmd;
  logic [PR_W-1:0]  pr;
  logic [CNT_W-1:0] rl, win;
  logic             dbg_stop, freeze, started, tick;

  assign freeze = dbg_halt & dbg_stop;

  wdg_bus_regs #(.CNT_W(CNT_W), .PR_W(PR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .widx(bus_widx),
    .hw_en(bus_hw_en), .wdata(bus_wdata), .rdata(bus_rdata), .cmd(cmd),
    .pr_o(pr), .rl_o(rl), .win_o(win), .dbg_stop_o(dbg_stop)
  );

  wdg_tick #(.PR_W(PR_W), .MAX_SHIFT(MAX_SHIFT)) u_tick (
    .clk(clk), .rst(rst), .run(started), .freeze(freeze),
    .clear(cmd.start | cmd.reload), .pr(pr), .tick(tick)
  );

  wdg_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cmd(cmd), .tick(tick), .freeze(freeze),
    .rl(rl), .win(win), .started(started), .rst_req(rst_req)
  );

  assert_req_needs_start_R4: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> started);
endmodule

// File: tb/test_keyed_window_wdt.sv
module test_keyed_window_wdt;
  localparam int BUSY = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_widx = '0;
  logic [1:0]  bus_hw_en = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_halt = 1'b0;
  logic        rst_req;

  int nchk = 0, nfail = 0, pulses = 0;
  string tag = "R8";

  always #5 clk = ~clk;

  keyed_window_wdt #(.BUSY_CYCLES(BUSY)) i_keyed_window_wdt (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_widx(bus_widx),
    .bus_hw_en(bus_hw_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_halt(dbg_halt), .rst_req(rst_req)
  );

  // behavioural reference model
  bit m_locked, m_dbg, m_started, m_req;
  int m_pr, m_rl, m_win, m_cnt, m_pre;
  int m_busy[3];
  int m_rdata;

  always @(posedge clk) begin
    automatic bit lo = bus_wr && bus_hw_en[0];
    automatic int kv = int'(bus_wdata[15:0]);
    automatic bit key = lo && bus_widx == 3'd0;
    automatic bit st = key && kv == 'hCCCC;
    automatic bit rl = key && kv == 'hAAAA;
    automatic bit frz = dbg_halt && m_dbg;
    automatic int sh = (m_pr > 6) ? 6 : m_pr;
    automatic int ratio = 4 * (1 << sh);
    if (rst) begin
      m_locked = 1; m_dbg = 0; m_started = 0; m_req = 0;
      m_pr = 0; m_rl = 'hFFF; m_win = 'hFFF; m_cnt = 'hFFF; m_pre = 0;
      foreach (m_busy[i]) m_busy[i] = 0;
      m_rdata = 0;
    end else begin
      m_req = 0;
      if (st) begin m_started = 1; m_cnt = m_rl; m_pre = 0; end
      else if (rl) begin
        if (m_started && m_win != 'hFFF && m_cnt > m_win) m_req = 1;
        m_cnt = m_rl; m_pre = 0;
      end else if (m_started && !frz) begin
        if (m_pre >= ratio - 1) begin
          m_pre = 0;
          if (m_cnt == 0) begin m_req = 1; m_cnt = m_rl; end
          else m_cnt = m_cnt - 1;
        end else m_pre = m_pre + 1;
      end
      if (bus_rd) begin
        case (bus_widx)
          3'd1: m_rdata = m_pr;
          3'd2: m_rdata = m_rl;
          3'd3: m_rdata = (m_busy[0] > 0 ? 1 : 0) + (m_busy[1] > 0 ? 2 : 0) + (m_busy[2] > 0 ? 4 : 0);
          3'd4: m_rdata = m_win;
          3'd5: m_rdata = m_dbg;
          default: m_rdata = 0;
        endcase
      end
      foreach (m_busy[i]) if (m_busy[i] > 0) m_busy[i]--;
      if (lo && !m_locked && bus_widx == 3'd1) begin m_pr = int'(bus_wdata[2:0]); m_busy[0] = BUSY; end
      if (lo && !m_locked && bus_widx == 3'd2) begin m_rl = int'(bus_wdata[11:0]); m_busy[1] = BUSY; end
      if (lo && !m_locked && bus_widx == 3'd4) begin m_win = int'(bus_wdata[11:0]); m_busy[2] = BUSY; end
      if (lo && bus_widx == 3'd5) m_dbg = bus_wdata[0];
      if (key) m_locked = (kv != 'h5555);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      nchk++;
      if (rst_req !== m_req) begin
        nfail++;
        $display("FAIL %s rst_req actual %0b expected %0b at %0t", tag, rst_req, m_req, $time);
      end
      nchk++;
      if (bus_rdata !== 32'(m_rdata)) begin
        nfail++;
        $display("FAIL %s rdata actual %0h expected %0h at %0t", tag, bus_rdata, m_rdata, $time);
      end
      if (rst_req === 1'b1) pulses++;
    end
  end

  task automatic wr(input logic [2:0] idx, input logic [1:0] hw, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_widx = idx; bus_hw_en = hw; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_hw_en = '0;
  endtask

  task automatic rd_check(input logic [2:0] idx, input logic [31:0] exp, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_widx = idx;
    @(negedge clk);
    bus_rd = 1'b0;
    nchk++;
    if (bus_rdata !== exp) begin
      nfail++;
      $display("FAIL %s read idx %0d actual %0h expected %0h", t, idx, bus_rdata, exp);
    end
  endtask

  task automatic chk(input int act, input int exp, input string t);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    automatic int p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset values and key reads as zero
    tag = "R8";
    rd_check(3'd0, 32'h0, "R8");
    rd_check(3'd1, 32'h0, "R8");
    rd_check(3'd2, 32'hFFF, "R8");
    rd_check(3'd4, 32'hFFF, "R8");
    rd_check(3'd3, 32'h0, "R8");
    rd_check(3'd5, 32'h0, "R8");
    // R2: locked write ignored
    tag = "R2";
    wr(3'd2, 2'b11, 32'h5);
    rd_check(3'd2, 32'hFFF, "R2");
    // R1 and R9: unlock, program, busy flags
    tag = "R1";
    wr(3'd0, 2'b11, 32'h5555);
    wr(3'd1, 2'b11, 32'h0);
    wr(3'd2, 2'b11, 32'h5);
    tag = "R9";
    rd_check(3'd3, 32'h3, "R9");
    idle(20);
    rd_check(3'd3, 32'h0, "R9");
    tag = "R1";
    rd_check(3'd2, 32'h5, "R1");
    // R11: upper-only key write does not relock, upper-only data write ignored
    tag = "R11";
    wr(3'd0, 2'b10, 32'h1234_0000);
    wr(3'd2, 2'b10, 32'h0007_0000);
    rd_check(3'd2, 32'h5, "R11");
    wr(3'd4, 2'b01, 32'h0000_0FFF);
    rd_check(3'd3, 32'h4, "R11");
    // R2: other key relocks
    tag = "R2";
    wr(3'd0, 2'b11, 32'h1234);
    wr(3'd2, 2'b11, 32'h7);
    rd_check(3'd2, 32'h5, "R2");
    chk(pulses, 0, "R6 no request before start");
    // R4, R6: start and time out: (5+1)*4 = 24 clocks
    tag = "R6";
    wr(3'd0, 2'b11, 32'hCCCC);
    idle(29);
    chk(pulses, 1, "R6 timeout pulse");
    // R4: keys do not stop it
    tag = "R4";
    wr(3'd0, 2'b11, 32'h0);
    p0 = pulses;
    idle(30);
    chk(pulses, p0 + 1, "R4 still running");
    // R5: periodic reloads
    tag = "R5";
    wr(3'd0, 2'b11, 32'hAAAA);
    p0 = pulses;
    for (int i = 0; i < 6; i++) begin
      idle(10);
      wr(3'd0, 2'b11, 32'hAAAA);
    end
    chk(pulses, p0, "R5 no request with reloads");
    // R7: window
    tag = "R7";
    wr(3'd0, 2'b11, 32'h5555);
    wr(3'd4, 2'b11, 32'h2);
    p0 = pulses;
    wr(3'd0, 2'b11, 32'hAAAA);
    idle(2);
    chk(pulses, p0 + 1, "R7 early reload");
    idle(14);
    p0 = pulses;
    wr(3'd0, 2'b11, 32'hAAAA);
    idle(2);
    chk(pulses, p0, "R7 reload inside window");
    // R10: debug freeze
    tag = "R10";
    wr(3'd5, 2'b11, 32'h1);
    dbg_halt = 1'b1;
    p0 = pulses;
    idle(100);
    chk(pulses, p0, "R10 frozen");
    dbg_halt = 1'b0;
    idle(30);
    chk(pulses, p0 + 1, "R10 resumes");
    wr(3'd5, 2'b11, 32'h0);
    dbg_halt = 1'b1;
    wr(3'd0, 2'b11, 32'hAAAA);
    p0 = pulses;
    idle(30);
    chk(pulses, p0 + 1, "R10 stop bit clear keeps counting");
    dbg_halt = 1'b0;
    // R3: clamped prescaler, divide 256, reload 1 -> request after 512 clocks
    tag = "R3";
    wr(3'd0, 2'b11, 32'h5555);
    wr(3'd4, 2'b11, 32'hFFF);
    wr(3'd1, 2'b11, 32'h7);
    wr(3'd2, 2'b11, 32'h1);
    wr(3'd0, 2'b11, 32'hAAAA);
    p0 = pulses;
    idle(300);
    chk(pulses, p0, "R3 slow tick");
    idle(250);
    chk(pulses, p0 + 1, "R3 clamp timeout");
    rd_check(3'd1, 32'h7, "R3");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule